// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level table from memory. A client hands it one address at a time, together with a flag saying whether the access is a write. The walker fetches the first-level entry relative to a directory base that the surrounding logic supplies. It then fetches the second-level entry and checks the present and permission bits. It answers either with the translated address or with one of two fault kinds.

The virtual address is split 10/10/12. The top ten bits pick a slot in the directory page. The next ten pick a slot in the second-level page. The low twelve bits are the byte offset inside a 4 KiB page. Each table is one 4 KiB page of 1024 word-sized entries. All memory traffic goes through a word-read port with a valid/ready request side and a response that may carry an error flag. When a walk ends in a page fault, the walker keeps the virtual address and the access direction of that walk in a fault record that stays readable until the next page fault.

Top module: `pgwalk_top`

## Requirements
- R1: While and right after reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, `fault_addr` is 0 and `fault_is_write` is 0.
- R2: The first memory read of a walk goes to `dir_base + 4*va[31:22]`, using the `dir_base` value present when the request was accepted.
- R3: The second read goes to `(L1 entry with bit 0 cleared) + 4*va[21:12]`.
- R4: A successful walk reports outcome 0 and the address `(L2 entry AND 0xFFFFF000) + va[11:0]`. A walk that ends in any fault reports address 0.
- R5: A first-level entry with bit 0 (present) clear ends the walk with outcome 1 (page fault), and no second read is issued.
- R6: A second-level entry with bit 0 clear ends the walk with outcome 1.
- R7: In the second-level entry, a read needs bit 1 and a write needs bit 2. A missing permission gives outcome 1. Bits 3 to 8 (cache attributes) have no effect on the result.
- R8: On outcome 1, `fault_addr` takes the walk's virtual address and `fault_is_write` its direction. Both hold their values through later successful walks and bus-error walks.
- R9: A memory response with `mem_rsp_err` set, at either level, ends the walk with outcome 2 (bus error).
- R10: After a request is accepted, `req_ready` stays low until the result handshake completes. While `rsp_valid` is high and `rsp_ready` low, the result holds steady.
- R11: While `mem_req_valid` is high and `mem_req_ready` low, the request holds and its address stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_base | input | 32 | Physical base of the first-level directory page |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Translated physical address, 0 on a fault |
| rsp_outcome | output | 2 | 0 translated, 1 page fault, 2 bus error |
| mem_req_valid | output | 1 | Word read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned (one cycle pulse) |
| mem_rsp_data | input | 32 | Entry word read from memory |
| mem_rsp_err | input | 1 | Returned read failed |
| fault_addr | output | 32 | Virtual address of the latest page fault |
| fault_is_write | output | 1 | Direction of the latest page fault |

## Verification
Translations are run for reads and writes against entries that grant read only, write only, or both, so that a direction mixup shows up as a wrong outcome. Entries with every cache-attribute bit set check that those bits do not change the result. The indices 1, 3, 5 and 1023 are used so that shifted or truncated index fields give wrong read addresses. A missing entry at each level, and an error response at each level, tell page faults apart from bus errors and confirm that a first-level miss stops the walk. The fault record is checked to stay unchanged across bus errors. The same walks are repeated with a stalling memory port, response latency and a slow client, which exercises the hold rules on both handshakes. The directory base is changed between walks to show that it is captured at acceptance.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int PW_ADDR_W = 32;
  localparam int PW_OFF_W  = 12;

  localparam int ENT_PRESENT_BIT = 0;
  localparam int ENT_READ_BIT    = 1;
  localparam int ENT_WRITE_BIT   = 2;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1_ASK,
    WS_L1_WAIT,
    WS_L2_ASK,
    WS_L2_WAIT,
    WS_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    OUT_OK         = 2'd0,
    OUT_PAGE_FAULT = 2'd1,
    OUT_BUS_ERR    = 2'd2
  } walk_outcome_e;

endpackage

// File: rtl/pgwalk_decode.sv
module pgwalk_decode
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = PW_ADDR_W,
  parameter int OFF_W  = PW_OFF_W,
  parameter int IDX_W  = (ADDR_W - OFF_W) / 2
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [ADDR_W-1:0] entry,
  input  logic              is_write,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr,
  output logic              entry_present,
  output logic              perm_ok,
  output logic [ADDR_W-1:0] phys_addr
);

  localparam int IDX2_LO = OFF_W;
  localparam int IDX1_LO = OFF_W + IDX_W;

  // base + 4 * index
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0]  idx);
    logic [ADDR_W-1:0] step;
    step = '0;
    step[IDX_W+1:0] = {idx, 2'b00};
    return base + step;
  endfunction

  function automatic logic [ADDR_W-1:0] table_base(input logic [ADDR_W-1:0] e);
    logic [ADDR_W-1:0] b;
    b = e;
    b[ENT_PRESENT_BIT] = 1'b0;
    return b;
  endfunction

  // page frame from entry, low bits replaced by the byte offset
  function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:0] e,
                                                  input logic [OFF_W-1:0]  off);
    logic [ADDR_W-1:0] p;
    p = e;
    p[OFF_W-1:0] = off;
    return p;
  endfunction

  function automatic logic grants(input logic [ADDR_W-1:0] e, input logic wr);
    return wr ? e[ENT_WRITE_BIT] : e[ENT_READ_BIT];
  endfunction

  logic [IDX_W-1:0] idx_dir;
  logic [IDX_W-1:0] idx_tbl;
  logic [OFF_W-1:0] byte_off;

  assign idx_dir  = va[IDX1_LO +: IDX_W];
  assign idx_tbl  = va[IDX2_LO +: IDX_W];
  assign byte_off = va[OFF_W-1:0];

  assign l1_addr       = slot_addr(dir_base, idx_dir);
  assign l2_addr       = slot_addr(table_base(entry), idx_tbl);
  assign entry_present = entry[ENT_PRESENT_BIT];
  assign perm_ok       = grants(entry, is_write);
  assign phys_addr     = page_addr(entry, byte_off);

endmodule

// File: rtl/pgwalk_fault_latch.sv
module pgwalk_fault_latch
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = PW_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] va,
  input  logic              is_write,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              fault_is_write
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_addr     <= '0;
      fault_is_write <= 1'b0;
    end else if (capture) begin
      fault_addr     <= va;
      fault_is_write <= is_write;
    end
  end

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = PW_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_outcome,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [ADDR_W-1:0] l1_addr,
  input  logic [ADDR_W-1:0] l2_addr,
  input  logic              entry_present,
  input  logic              perm_ok,
  input  logic [ADDR_W-1:0] phys_addr,
  output logic [ADDR_W-1:0] cur_va,
  output logic [ADDR_W-1:0] cur_base,
  output logic              cur_write,
  output logic              fault_evt
);

  walk_state_e   state_q;
  walk_outcome_e kind_q;
  logic [ADDR_W-1:0] va_q, base_q, l2a_q, paddr_q;
  logic wr_q;

  // named events for the checks below
  logic accept_evt, l1_data, l2_data;
  logic bus_err_evt, l1_miss_evt, l2_miss_evt, leaf_ok_evt;

  assign accept_evt  = (state_q == WS_IDLE) && req_valid;
  assign l1_data     = (state_q == WS_L1_WAIT) && mem_rsp_valid;
  assign l2_data     = (state_q == WS_L2_WAIT) && mem_rsp_valid;
  assign bus_err_evt = (l1_data || l2_data) && mem_rsp_err;
  assign l1_miss_evt = l1_data && !mem_rsp_err && !entry_present;
  assign l2_miss_evt = l2_data && !mem_rsp_err && (!entry_present || !perm_ok);
  assign leaf_ok_evt = l2_data && !mem_rsp_err && entry_present && perm_ok;
  assign fault_evt   = l1_miss_evt || l2_miss_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      kind_q  <= OUT_OK;
      va_q    <= '0;
      base_q  <= '0;
      l2a_q   <= '0;
      paddr_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        WS_IDLE: if (accept_evt) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          base_q  <= dir_base;
          state_q <= WS_L1_ASK;
        end
        WS_L1_ASK: if (mem_req_ready) state_q <= WS_L1_WAIT;
        WS_L1_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            kind_q  <= OUT_BUS_ERR;
            paddr_q <= '0;
            state_q <= WS_DONE;
          end else if (!entry_present) begin
            kind_q  <= OUT_PAGE_FAULT;
            paddr_q <= '0;
            state_q <= WS_DONE;
          end else begin
            l2a_q   <= l2_addr;
            state_q <= WS_L2_ASK;
          end
        end
        WS_L2_ASK: if (mem_req_ready) state_q <= WS_L2_WAIT;
        WS_L2_WAIT: if (mem_rsp_valid) begin
          state_q <= WS_DONE;
          if (mem_rsp_err) begin
            kind_q  <= OUT_BUS_ERR;
            paddr_q <= '0;
          end else if (leaf_ok_evt) begin
            kind_q  <= OUT_OK;
            paddr_q <= phys_addr;
          end else begin
            kind_q  <= OUT_PAGE_FAULT;
            paddr_q <= '0;
          end
        end
        WS_DONE: if (rsp_ready) state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == WS_IDLE);
  assign rsp_valid     = (state_q == WS_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_outcome   = kind_q;
  assign mem_req_valid = (state_q == WS_L1_ASK) || (state_q == WS_L2_ASK);
  assign mem_req_addr  = (state_q == WS_L2_ASK) ? l2a_q : l1_addr;
  assign cur_va        = va_q;
  assign cur_base      = base_q;
  assign cur_write     = wr_q;

  // R11: a stalled memory request keeps its address
  p_ask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10: an unaccepted result stays put
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_outcome));

  // R10: acceptance closes the request side
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !rsp_valid);

  // R9: error data ends the walk as a bus error
  p_bus_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_evt |=> rsp_valid && rsp_outcome == OUT_BUS_ERR);

  // R5: a directory miss never issues a second read
  p_l1_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    l1_miss_evt |=> !mem_req_valid && rsp_valid && rsp_outcome == OUT_PAGE_FAULT);

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = PW_ADDR_W,
  parameter int OFF_W  = PW_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_outcome,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              fault_is_write
);

  localparam int IDX_W = (ADDR_W - OFF_W) / 2;

  logic [ADDR_W-1:0] l1_addr, l2_addr, phys_addr;
  logic [ADDR_W-1:0] cur_va, cur_base;
  logic entry_present, perm_ok, cur_write, fault_evt;

  pgwalk_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_decode (
    .va            (cur_va),
    .dir_base      (cur_base),
    .entry         (mem_rsp_data),
    .is_write      (cur_write),
    .l1_addr       (l1_addr),
    .l2_addr       (l2_addr),
    .entry_present (entry_present),
    .perm_ok       (perm_ok),
    .phys_addr     (phys_addr)
  );

  pgwalk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir_base      (dir_base),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_outcome   (rsp_outcome),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .l1_addr       (l1_addr),
    .l2_addr       (l2_addr),
    .entry_present (entry_present),
    .perm_ok       (perm_ok),
    .phys_addr     (phys_addr),
    .cur_va        (cur_va),
    .cur_base      (cur_base),
    .cur_write     (cur_write),
    .fault_evt     (fault_evt)
  );

  pgwalk_fault_latch #(.ADDR_W(ADDR_W)) u_fault (
    .clk            (clk),
    .rst_n          (rst_n),
    .capture        (fault_evt),
    .va             (cur_va),
    .is_write       (cur_write),
    .fault_addr     (fault_addr),
    .fault_is_write (fault_is_write)
  );

  // R8: a reported page fault is backed by the fault record
  p_fault_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_outcome == OUT_PAGE_FAULT |->
      fault_addr == cur_va && fault_is_write == cur_write);

  // R4: a translated address keeps the page offset of the request
  p_ok_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_outcome == OUT_OK |-> rsp_paddr[OFF_W-1:0] == cur_va[OFF_W-1:0]);

  // R4: faults carry no address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_outcome != OUT_OK |-> rsp_paddr == '0);

endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;

  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] dir_base = '0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_outcome;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] fault_addr;
  logic        fault_is_write;

  pgwalk_top uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_outcome(rsp_outcome),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .fault_addr(fault_addr), .fault_is_write(fault_is_write)
  );

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  outc;
    logic [31:0] faddr;
    logic        fwr;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  string       addr_tag_q[$];
  logic [31:0] mem_img[logic [31:0]];
  bit          err_img[logic [31:0]];

  int n_chk = 0, n_bad = 0;
  int lat = 0;
  bit stall = 0, slow_client = 0;
  logic [31:0] exp_faddr = '0;
  logic        exp_fwr = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  function automatic bit errs(input logic [31:0] a);
    return err_img.exists(a) ? err_img[a] : 1'b0;
  endfunction

  // memory model: one outstanding read, optional stall and latency
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;
  bit          held = 0;
  logic [31:0] held_addr = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (rst_n) begin
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend_addr);
          mem_rsp_err   = errs(pend_addr);
          pend = 0;
        end else cnt--;
      end
      if (held) begin
        check("R11", "stalled read still offered", {31'b0, mem_req_valid}, 32'h1);
        check("R11", "stalled read address", mem_req_addr, held_addr);
      end
      mem_req_ready = stall ? ~mem_req_ready : 1'b1;
      held = mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (addr_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R5 unexpected read: actual 0x%08h expected none", mem_req_addr);
        end else begin
          check(addr_tag_q.pop_front(), "entry read address", mem_req_addr, addr_q.pop_front());
        end
        pend = 1; cnt = lat; pend_addr = mem_req_addr;
      end
    end
  end

  // result monitor
  bit          rheld = 0;
  logic [31:0] rheld_pa = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rheld) begin
        check("R10", "held result valid", {31'b0, rsp_valid}, 32'h1);
        check("R10", "held result address", rsp_paddr, rheld_pa);
      end
      rsp_ready = slow_client ? ~rsp_ready : 1'b1;
      if (rsp_valid) check("R10", "busy while result pending", {31'b0, req_ready}, 32'h0);
      rheld = rsp_valid && !rsp_ready;
      rheld_pa = rsp_paddr;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R10 unexpected result: actual 0x%08h expected none", rsp_paddr);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.tag, "outcome", {30'b0, rsp_outcome}, {30'b0, e.outc});
          check(e.tag, "address", rsp_paddr, e.paddr);
          check("R8", "fault address", fault_addr, e.faddr);
          check("R8", "fault direction", {31'b0, fault_is_write}, {31'b0, e.fwr});
        end
      end
    end
  end

  // independent prediction from the requirements
  task automatic predict(input logic [31:0] va, input logic wr);
    exp_t e;
    logic [31:0] a1, a2, e1, e2;
    bit perm;
    e.paddr = 32'h0;
    a1 = dir_base + va[31:22] * 4;
    addr_q.push_back(a1); addr_tag_q.push_back("R2");
    if (errs(a1)) begin
      e.outc = 2'd2; e.tag = "R9";
    end else begin
      e1 = rd(a1);
      if (!e1[0]) begin
        e.outc = 2'd1; e.tag = "R5";
      end else begin
        a2 = (e1 & 32'hFFFF_FFFE) + va[21:12] * 4;
        addr_q.push_back(a2); addr_tag_q.push_back("R3");
        e2 = rd(a2);
        perm = wr ? e2[2] : e2[1];
        if (errs(a2)) begin
          e.outc = 2'd2; e.tag = "R9";
        end else if (!e2[0]) begin
          e.outc = 2'd1; e.tag = "R6";
        end else if (!perm) begin
          e.outc = 2'd1; e.tag = "R7";
        end else begin
          e.outc = 2'd0; e.tag = "R4";
          e.paddr = (e2 & 32'hFFFF_F000) + {20'b0, va[11:0]};
        end
      end
    end
    if (e.outc == 2'd1) begin
      exp_faddr = va; exp_fwr = wr;
    end
    e.faddr = exp_faddr; e.fwr = exp_fwr;
    exp_q.push_back(e);
  endtask

  task automatic walk(input logic [31:0] va, input logic wr);
    predict(va, wr);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "busy after acceptance", {31'b0, req_ready}, 32'h0);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_set();
    dir_base = 32'h0001_0000;
    walk(32'h0040_3ABC, 1'b0); // R4 read hit
    walk(32'h0040_3ABC, 1'b1); // R7 write without permission
    walk(32'h0040_5010, 1'b1); // R7 attribute bits set, write ok
    walk(32'h0040_5010, 1'b0); // R7 attribute bits set, read ok
    walk(32'h0040_7444, 1'b0); // R7 write-only entry read
    walk(32'h0040_7444, 1'b1); // R7 write-only entry write
    walk(32'h0080_0000, 1'b0); // R5 directory miss
    walk(32'h0040_9000, 1'b1); // R6 table miss
    walk(32'h00C0_1234, 1'b0); // R9 error on first read, R8 record kept
    walk(32'h0040_B000, 1'b1); // R9 error on second read
    walk(32'hFFFF_FFFF, 1'b0); // R2 R3 top indices
    dir_base = 32'h0004_0000;
    walk(32'h0040_3ABC, 1'b0); // R2 new base
  endtask

  initial begin
    mem_img[32'h0001_0004] = 32'h0002_0001;
    mem_img[32'h0002_000C] = 32'h1234_5003;
    mem_img[32'h0002_0014] = 32'h5555_51FF;
    mem_img[32'h0002_001C] = 32'hAAAA_A005;
    mem_img[32'h0002_0024] = 32'h7777_7006;
    err_img[32'h0001_000C] = 1'b1;
    err_img[32'h0002_002C] = 1'b1;
    mem_img[32'h0001_0FFC] = 32'h0003_0001;
    mem_img[32'h0003_0FFC] = 32'h9ABC_D003;
    mem_img[32'h0004_0004] = 32'h0005_0001;
    mem_img[32'h0005_000C] = 32'h0BAD_0003;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready in reset", {31'b0, req_ready}, 32'h1);
    check("R1", "no result in reset", {31'b0, rsp_valid}, 32'h0);
    check("R1", "no read in reset", {31'b0, mem_req_valid}, 32'h0);
    check("R1", "fault address in reset", fault_addr, 32'h0);
    check("R1", "fault direction in reset", {31'b0, fault_is_write}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", {31'b0, req_ready}, 32'h1);

    run_set();
    stall = 1; lat = 3; slow_client = 1;
    run_set();

    check("R5", "no reads left over", addr_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule